// File: doc/BRIEF.md
# Dual-Pin PDM Microphone Capture Front End

This block clocks up to four pulse-density-modulated microphones and collects their one-bit sample streams. Two data pins are shared by the microphones. On a pin in double-edge mode, one microphone drives data for the rising edge of the microphone clock (left channel) and a second microphone drives data for the falling edge (right channel). On a pin in single-edge mode, only the rising-edge (left) channel is taken. Each pin feeds its own stereo capture path. The result is four channel outputs, each with a one-cycle valid pulse, which feed downstream decimation filters.

The microphone clock is derived from the system clock by an even divider: each phase lasts `half_div` system cycles. The clock runs only when the microphone function is enabled, the power-state code selects full power, and at least one pin is enabled. It starts and stops only during a low phase. When the microphone function is disabled, the clock pad driver is released so that an external weak pull-down holds the line.

Two configurations cover the microphone counts. With one pin double-edge and the other single-edge, three microphones are served. With both pins double-edge, four are served.

Top module: `pdm_mic_capture`

## Requirements
- R1: While running, every high phase and every low phase of `mclk_out` lasts exactly `max(half_div, 2)` system cycles.
- R2: `mclk_out` may rise only when `mic_func_en` is 1, `pwr_state` is 2'b00 (full power), and `pin_en` is non-zero. With any of these conditions false, the clock finishes its current high phase, stays low, and produces no edges.
- R3: A high phase is never shortened by a change of enables, power state or function enable. After a start, the first rising edge comes no sooner than one full half period.
- R4: `mclk_oe` follows `mic_func_en`. In the low-power codes 2'b01, 2'b10 and 2'b11 with the function enabled, the output stays driven low with `mclk_oe` at 1.
- R5: Channel 2p carries pin p's rising-edge sample and channel 2p+1 carries its falling-edge sample. The valid pulse is one cycle long and occurs in the cycle in which `mclk_out` first shows the matching edge.
- R6: A pin whose `pin_dual` bit is 0 (single-edge) produces valids only on its left channel 2p and never on channel 2p+1.
- R7: A pin whose `pin_en` bit is 0 produces no valids on either of its channels, and its data input is ignored.
- R8: No valid pulse follows any cycle in which the run condition of R2 was false. Captures stop at once, even while a final high phase completes.
- R9: Each pin passes through a two-flop synchronizer. A sample reflects the pin level held for at least three system cycles before the capturing microphone-clock edge.
- R10: Synchronous reset leaves `mclk_out` low, all valids low and all channel data 0.
- R11: With both pins enabled in double-edge mode, all four channels deliver independent streams, two stereo pairs, one per pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mic_func_en | input | 1 | Microphone function enabled; drives the clock pad enable |
| pwr_state | input | 2 | Power-state code, 0 = full power, 1 to 3 = reduced |
| pin_en | input | 2 | Per-pin capture enable |
| pin_dual | input | 2 | Per-pin mode: 1 = double-edge, 0 = single-edge |
| half_div | input | DIV_W | System cycles per microphone-clock phase (values below 2 act as 2) |
| pdm_in | input | 2 | Microphone data pins |
| mclk_out | output | 1 | Microphone clock |
| mclk_oe | output | 1 | Microphone clock pad drive enable |
| ch_data | output | 4 | Captured bit per channel (2p left, 2p+1 right) |
| ch_valid | output | 4 | One-cycle sample strobe per channel |

## Verification
The properties assume that `half_div` changes only while the clock is stopped and low. The minimum-phase checks depend on this, because they look only one cycle past each edge. The properties also assume that reset is held from time zero, so that no past value is read before a defined one. The stimulus changes the divider only after the run condition has been false for longer than a full period. A microphone model changes each data pin only right after a microphone-clock edge, which keeps the pin level steady across the synchronizer window. Data comparisons are turned off for the two-cycle divider setting, where that window is too short.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned NUM_CH   = 2 * NUM_PINS;

    typedef enum logic [1:0] {
        PWR_FULL  = 2'd0,
        PWR_LOW1  = 2'd1,
        PWR_LOW2  = 2'd2,
        PWR_LOW3  = 2'd3
    } pwr_code_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_stb_t;

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
    import pdm_cap_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mclk,
    output edge_stb_t        stb
);

    typedef struct packed {
        logic             active;
        logic             mclk;
        logic [DIV_W-1:0] cnt;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    logic [DIV_W-1:0] last_cnt;
    logic             wrap;

    always_comb begin
        st_d     = st_q;
        stb      = '0;
        last_cnt = (half_div < DIV_W'(2)) ? DIV_W'(1) : half_div - DIV_W'(1);
        wrap     = (st_q.cnt >= last_cnt);
        if (!st_q.active) begin
            if (run) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end
        end else if (!run && !st_q.mclk) begin
            // stop only while low
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.mclk = ~st_q.mclk;
            stb.rise  = run & ~st_q.mclk;
            stb.fall  = run &  st_q.mclk;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mclk = st_q.mclk;

endmodule

// File: rtl/pdm_sync.sv
module pdm_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/pdm_pin_cap.sv
module pdm_pin_cap
    import pdm_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_stb_t  stb,
    input  logic       en,
    input  logic       dual,
    input  logic       din,
    output logic [1:0] data,
    output logic [1:0] valid
);

    typedef struct packed {
        logic [1:0] data;
        logic [1:0] valid;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = '0;
        if (stb.rise && en) begin
            st_d.data[0]  = din;
            st_d.valid[0] = 1'b1;
        end
        if (stb.fall && en && dual) begin
            st_d.data[1]  = din;
            st_d.valid[1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;

endmodule

// File: rtl/pdm_mic_capture.sv
module pdm_mic_capture
    import pdm_cap_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mic_func_en,
    input  logic [1:0]        pwr_state,
    input  logic [1:0]        pin_en,
    input  logic [1:0]        pin_dual,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [1:0]        pdm_in,
    output logic              mclk_out,
    output logic              mclk_oe,
    output logic [3:0]        ch_data,
    output logic [3:0]        ch_valid
);

    logic                run;
    edge_stb_t           stb;
    logic [NUM_PINS-1:0] pin_sync;

    assign run     = mic_func_en && (pwr_state == PWR_FULL) && (|pin_en);
    assign mclk_oe = mic_func_en;

    pdm_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_div),
        .mclk     (mclk_out),
        .stb      (stb)
    );

    pdm_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pdm_in),
        .dout (pin_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pdm_pin_cap i_cap (
            .clk   (clk),
            .rst   (rst),
            .stb   (stb),
            .en    (pin_en[p]),
            .dual  (pin_dual[p]),
            .din   (pin_sync[p]),
            .data  (ch_data[2*p +: 2]),
            .valid (ch_valid[2*p +: 2])
        );
    end

endmodule

// File: rtl/pdm_mic_capture_chk.sv
module pdm_mic_capture_chk (
    input logic       clk,
    input logic       rst,
    input logic       mic_func_en,
    input logic [1:0] pwr_state,
    input logic [1:0] pin_en,
    input logic [1:0] pin_dual,
    input logic       mclk_out,
    input logic       mclk_oe,
    input logic [3:0] ch_valid
);

    logic run_ok;
    assign run_ok = mic_func_en && (pwr_state == 2'b00) && (pin_en != 2'b00);

    a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(mclk_out) |-> $past(run_ok));

    a_r3_high_not_runt: assert property (@(posedge clk) disable iff (rst)
        $rose(mclk_out) |=> mclk_out);

    a_r3_low_not_runt: assert property (@(posedge clk) disable iff (rst)
        $fell(mclk_out) |=> !mclk_out);

    a_r4_oe_follows_func: assert property (@(posedge clk) disable iff (rst)
        !mic_func_en |-> !mclk_oe);

    a_r5_left0_on_rise: assert property (@(posedge clk) disable iff (rst)
        ch_valid[0] |-> $rose(mclk_out));

    a_r5_left1_on_rise: assert property (@(posedge clk) disable iff (rst)
        ch_valid[2] |-> $rose(mclk_out));

    a_r5_right0_on_fall: assert property (@(posedge clk) disable iff (rst)
        ch_valid[1] |-> $fell(mclk_out));

    a_r5_right1_on_fall: assert property (@(posedge clk) disable iff (rst)
        ch_valid[3] |-> $fell(mclk_out));

    a_r6_right0_needs_dual: assert property (@(posedge clk) disable iff (rst)
        ch_valid[1] |-> $past(pin_dual[0]));

    a_r6_right1_needs_dual: assert property (@(posedge clk) disable iff (rst)
        ch_valid[3] |-> $past(pin_dual[1]));

    a_r7_pin0_enabled: assert property (@(posedge clk) disable iff (rst)
        (ch_valid[1:0] != 2'b00) |-> $past(pin_en[0]));

    a_r7_pin1_enabled: assert property (@(posedge clk) disable iff (rst)
        (ch_valid[3:2] != 2'b00) |-> $past(pin_en[1]));

    a_r8_valid_needs_run: assert property (@(posedge clk) disable iff (rst)
        (ch_valid != 4'b0000) |-> $past(run_ok));

    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_valid == 4'b0000 && !mclk_out));

endmodule

bind pdm_mic_capture pdm_mic_capture_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .mic_func_en (mic_func_en),
    .pwr_state   (pwr_state),
    .pin_en      (pin_en),
    .pin_dual    (pin_dual),
    .mclk_out    (mclk_out),
    .mclk_oe     (mclk_oe),
    .ch_valid    (ch_valid)
);

// File: tb/test_pdm_mic_capture.sv
module test_pdm_mic_capture;

    localparam int unsigned DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mic_func_en = 1'b0;
    logic [1:0]       pwr_state = 2'b00;
    logic [1:0]       pin_en = 2'b00;
    logic [1:0]       pin_dual = 2'b00;
    logic [DIV_W-1:0] half_div = 8'd4;
    logic [1:0]       pdm_in = 2'b00;
    logic             mclk_out, mclk_oe;
    logic [3:0]       ch_data, ch_valid;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt [4];
    int nedge = 0;
    int exp_half = 4;
    bit data_chk_en = 1'b1;
    logic [3:0] exp_bit = 4'b0000;

    always #5 clk = ~clk;

    pdm_mic_capture #(.DIV_W(DIV_W)) i_pdm_mic_capture (
        .clk(clk), .rst(rst), .mic_func_en(mic_func_en), .pwr_state(pwr_state),
        .pin_en(pin_en), .pin_dual(pin_dual), .half_div(half_div), .pdm_in(pdm_in),
        .mclk_out(mclk_out), .mclk_oe(mclk_oe), .ch_data(ch_data), .ch_valid(ch_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // microphone model and monitor
    initial begin
        logic       prev;
        int         len;
        bit         seen_rise;
        logic [15:0] lfsr;
        prev = 1'b0; len = 0; seen_rise = 1'b0; lfsr = 16'hACE1;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = 1'b0; len = 0; seen_rise = 1'b0;
            end else begin
                for (int c = 0; c < 4; c++) begin
                    if (ch_valid[c]) begin
                        vcnt[c]++;
                        if (data_chk_en)
                            chk($sformatf("R9 R5 channel %0d data", c), int'(ch_data[c]), int'(exp_bit[c]));
                    end
                end
                if (mclk_out !== prev) begin
                    nedge++;
                    if (prev == 1'b1)
                        chk("R1 R3 high phase length", len, exp_half);
                    else if (seen_rise)
                        chk("R1 R3 low phase at least half", int'(len >= exp_half), 1);
                    if (mclk_out) seen_rise = 1'b1;
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    for (int p = 0; p < 2; p++) begin
                        pdm_in[p] = lfsr[p];
                        if (mclk_out) exp_bit[2*p+1] = lfsr[p];
                        else          exp_bit[2*p]   = lfsr[p];
                    end
                    len  = 1;
                    prev = mclk_out;
                end else begin
                    len++;
                end
            end
        end
    end

    task automatic clear_counts();
        for (int c = 0; c < 4; c++) vcnt[c] = 0;
        nedge = 0;
    endtask

    task automatic cfg(input logic f, input logic [1:0] pw, input logic [1:0] en, input logic [1:0] du);
        @(negedge clk);
        mic_func_en = f; pwr_state = pw; pin_en = en; pin_dual = du;
    endtask

    task automatic set_half(input int h);
        cfg(1'b0, 2'b00, 2'b00, 2'b00);
        repeat (40) @(negedge clk);
        half_div = DIV_W'(h);
        exp_half = (h < 2) ? 2 : h;
        data_chk_en = (exp_half >= 4);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 mclk low after reset", int'(mclk_out), 0);
        chk("R10 valids low after reset", int'(ch_valid), 0);
        chk("R10 data zero after reset", int'(ch_data), 0);
    endtask

    task automatic t_four_mics();
        cfg(1'b1, 2'b00, 2'b11, 2'b11);
        clear_counts();
        repeat (200) @(negedge clk);
        for (int c = 0; c < 4; c++)
            chk($sformatf("R11 channel %0d streams", c), int'(vcnt[c] >= 20), 1);
        chk("R4 oe driven while running", int'(mclk_oe), 1);
    endtask

    task automatic t_mixed();
        cfg(1'b1, 2'b00, 2'b11, 2'b01);
        clear_counts();
        repeat (200) @(negedge clk);
        chk("R6 single-edge pin right channel silent", vcnt[3], 0);
        chk("R6 single-edge pin left channel active", int'(vcnt[2] >= 20), 1);
        chk("R5 double-edge pin right channel active", int'(vcnt[1] >= 20), 1);
    endtask

    task automatic t_one_pin();
        cfg(1'b1, 2'b00, 2'b10, 2'b10);
        clear_counts();
        repeat (200) @(negedge clk);
        chk("R7 disabled pin left silent", vcnt[0], 0);
        chk("R7 disabled pin right silent", vcnt[1], 0);
        chk("R7 enabled pin still streams", int'(vcnt[3] >= 20), 1);
    endtask

    task automatic t_low_power();
        for (int pw = 1; pw < 4; pw++) begin
            cfg(1'b1, 2'b00, 2'b11, 2'b11);
            repeat (37 + pw) @(negedge clk);
            cfg(1'b1, 2'(pw), 2'b11, 2'b11);
            clear_counts();
            repeat (100) @(negedge clk);
            chk($sformatf("R8 no valids in state %0d", pw),
                vcnt[0] + vcnt[1] + vcnt[2] + vcnt[3], 0);
            chk($sformatf("R2 clock settles in state %0d", pw), int'(nedge <= 1), 1);
            clear_counts();
            repeat (40) @(negedge clk);
            chk($sformatf("R2 clock stays low in state %0d", pw), nedge, 0);
            chk($sformatf("R4 oe kept in state %0d", pw), int'(mclk_oe), 1);
        end
    endtask

    task automatic t_no_pins();
        cfg(1'b1, 2'b00, 2'b00, 2'b11);
        repeat (20) @(negedge clk);
        clear_counts();
        repeat (60) @(negedge clk);
        chk("R2 no edges with no pin enabled", nedge, 0);
        chk("R2 clock low with no pin enabled", int'(mclk_out), 0);
    endtask

    task automatic t_func_off();
        cfg(1'b0, 2'b00, 2'b11, 2'b11);
        @(negedge clk);
        chk("R4 oe released when function off", int'(mclk_oe), 0);
        repeat (20) @(negedge clk);
        clear_counts();
        repeat (60) @(negedge clk);
        chk("R2 no edges when function off", nedge, 0);
        chk("R8 no valids when function off", vcnt[0] + vcnt[1] + vcnt[2] + vcnt[3], 0);
    endtask

    task automatic t_stop_mid();
        for (int k = 0; k < 12; k++) begin
            cfg(1'b1, 2'b00, 2'b11, 2'b11);
            repeat (30 + k) @(negedge clk);
            cfg(1'b1, 2'b00, 2'b00, 2'b11);
            clear_counts();
            repeat (30) @(negedge clk);
            chk($sformatf("R8 no valid after stop offset %0d", k),
                vcnt[0] + vcnt[1] + vcnt[2] + vcnt[3], 0);
            chk($sformatf("R3 clock ends low offset %0d", k), int'(mclk_out), 0);
        end
    endtask

    task automatic t_divider(input int h);
        set_half(h);
        cfg(1'b1, 2'b00, 2'b01, 2'b01);
        clear_counts();
        repeat (40 * exp_half) @(negedge clk);
        chk($sformatf("R1 edge count for half %0d", h), int'(nedge >= 38 && nedge <= 40), 1);
        chk($sformatf("R1 left channel rate for half %0d", h), int'(vcnt[0] >= 19 && vcnt[0] <= 20), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_counts();
        t_reset();
        t_four_mics();
        t_mixed();
        t_one_pin();
        t_low_power();
        t_no_pins();
        t_func_off();
        t_stop_mid();
        t_divider(6);
        t_divider(1);
        t_divider(0);
        t_divider(4);
        t_four_mics();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule